// File: doc/BRIEF.md
# Daisy-Chain Configuration Node

This block is one node in a serial configuration chain. A single bit-serial stream enters on `ser_in` and is paced by the external configuration clock `cfg_clk`, one bit per rising edge. The node first hunts for its own sync pattern. While it hunts, it copies every bit it receives onto `ser_out`, one half-period later on the falling edge. Those bits belong to nodes further down the chain, so the next node can capture them on its following rising edge. As a result, the node nearest the stream source finishes configuring last.

Once its sync pattern is seen, the node reads a 32-bit length, then that many payload bits, then a 32-bit CRC. Payload bits are handed out on `pl_valid`/`pl_bit` to the configuration storage, which lives outside this block. The node checks the CRC over its own payload only. If the CRC matches, the node stops pulling the shared open-drain done line and waits until that line reads high. It then steps through two one-clock phases and raises `configured`. If the CRC does not match, the node locks into an error state until reset.

The bit stream has no ready signal and no back-pressure. The upstream clock sets the pace, and every rising edge delivers a bit that must be taken. `pl_valid` is a one-cycle qualifier that the payload consumer cannot stall.

Top module: `chain_cfg_node`

## Requirements
- R1: `ser_in` is sampled on each rising edge of `cfg_clk`. Every bit sampled while the node is hunting is driven on `ser_out` at the next falling edge. This includes the bits of the node's own sync pattern. `ser_out` does not change on rising edges.
- R2: `ser_out` is 1 after reset, and it stays 1 from the first bit after the sync pattern onward.
- R3: A frame is the sync pattern (default 32'h3C5A96E1), then a 32-bit payload length in bits, then the payload, then a 32-bit CRC. All fields are sent most significant bit first.
- R4: Each payload bit appears on `pl_bit`, with `pl_valid` high, during the cycle after the rising edge that sampled it. Length and CRC bits never raise `pl_valid`.
- R5: The CRC is computed one bit per edge over the payload bits only. It uses polynomial 0x04C11DB7 and starts from all ones. Bits are shifted in most significant first, with no reflection and no final inversion. A zero-length payload therefore expects 32'hFFFFFFFF.
- R6: `done_pull` (1 = pull the shared done line low) is 1 from reset until the received CRC matches.
- R7: After a CRC match, `done_pull` is 0. The node stays in the release phase, with `configured` at 0, for as long as `done_line` reads 0.
- R8: The first rising edge that samples `done_line` high ends the release phase. Two one-clock phases follow. `configured` rises after the third such rising edge and then stays high until reset.
- R9: After a CRC mismatch, `crc_err` is 1 and `done_pull` is 1. Further stream bits and `done_line` have no effect until `rst_n` goes low.
- R10: `configured` and `crc_err` are never both 1, and `done_pull` is never 1 while `configured` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock from upstream |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial stream in, sampled on rising edge |
| ser_out | output | 1 | Serial stream to the next node, changes on falling edge |
| done_pull | output | 1 | Output enable of the open-drain done driver (1 = pull low) |
| done_line | input | 1 | Sampled level of the shared done line |
| pl_valid | output | 1 | Qualifies `pl_bit` as a payload bit |
| pl_bit | output | 1 | Payload bit for configuration storage |
| configured | output | 1 | Start-up sequence complete |
| crc_err | output | 1 | CRC mismatch seen, held until reset |

## Verification
The node is fed several different streams. One is a short burst of downstream bits followed by a 20-bit frame. Another has a different burst and a 37-bit payload. A third is a zero-length frame whose CRC is the all-ones start value. A fourth is a frame whose CRC has one bit flipped. The forwarding runs show whether `ser_out` follows the hunted bits on the falling edge rather than the rising edge. The payload runs separate payload bits from length and CRC bits. The zero-length and flipped-CRC frames separate a correct seed and compare from a wrong one. Holding `done_line` low and then raising it pins down how many edges the start-up phases take.

// File: rtl/chain_cfg_pkg.sv
package chain_cfg_pkg;
  typedef enum logic [3:0] {
    ST_HUNT,
    ST_LEN,
    ST_LOAD,
    ST_CRC,
    ST_REL,
    ST_PHA,
    ST_PHB,
    ST_CFG,
    ST_ERR
  } node_state_e;
endpackage

// File: rtl/ccs_sync_det.sv
module ccs_sync_det #(
  parameter int unsigned          W       = 32,
  parameter logic [W-1:0]         PATTERN = 32'h3C5A_96E1
) (
  input  logic cfg_clk,
  input  logic rst_n,
  input  logic en,
  input  logic bit_in,
  output logic hit
);
  logic [W-1:0] win;
  logic [W-1:0] win_nxt;

  assign win_nxt = {win[W-2:0], bit_in};
  assign hit     = en && (win_nxt == PATTERN);

  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n)  win <= '0;
    else if (en) win <= win_nxt;
  end
endmodule

// File: rtl/ccs_crc_ser.sv
module ccs_crc_ser #(
  parameter int unsigned  W    = 32,
  parameter logic [W-1:0] POLY = 32'h04C1_1DB7,
  parameter logic [W-1:0] SEED = '1
) (
  input  logic         cfg_clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         en,
  input  logic         bit_in,
  output logic [W-1:0] crc
);
  logic         fb;
  logic [W-1:0] crc_nxt;

  assign fb      = crc[W-1] ^ bit_in;
  assign crc_nxt = {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);

  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n)    crc <= SEED;
    else if (init) crc <= SEED;
    else if (en)   crc <= crc_nxt;
  end
endmodule

// File: rtl/ccs_fwd.sv
module ccs_fwd (
  input  logic cfg_clk,
  input  logic rst_n,
  input  logic pass,
  input  logic bit_in,
  output logic ser_out
);
  logic rx_q;
  logic pass_q;

  // capture side: rising edge
  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= 1'b1;
      pass_q <= 1'b0;
    end else begin
      rx_q   <= bit_in;
      pass_q <= pass;
    end
  end

  // launch side: falling edge, idle high
  always_ff @(negedge cfg_clk or negedge rst_n) begin
    if (!rst_n) ser_out <= 1'b1;
    else        ser_out <= pass_q ? rx_q : 1'b1;
  end
endmodule

// File: rtl/ccs_seq.sv
module ccs_seq
  import chain_cfg_pkg::*;
#(
  parameter int unsigned LEN_W = 32,
  parameter int unsigned CRC_W = 32
) (
  input  logic             cfg_clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             sync_hit,
  input  logic [CRC_W-1:0] crc_val,
  input  logic             done_line,
  output node_state_e      state,
  output logic             hunting,
  output logic             crc_init,
  output logic             crc_en,
  output logic             pl_valid,
  output logic             pl_bit
);
  localparam logic [LEN_W-1:0] LEN_LAST = LEN_W'(LEN_W - 1);
  localparam logic [LEN_W-1:0] CRC_LAST = LEN_W'(CRC_W - 1);

  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] len_sr;
  logic [CRC_W-1:0] crc_sr;
  logic [LEN_W-1:0] len_word;
  logic [CRC_W-1:0] crc_word;

  assign len_word = {len_sr[LEN_W-2:0], ser_in};
  assign crc_word = {crc_sr[CRC_W-2:0], ser_in};
  assign hunting  = (state == ST_HUNT);
  assign crc_init = (state == ST_HUNT) || (state == ST_LEN);
  assign crc_en   = (state == ST_LOAD);

  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_HUNT;
      cnt      <= '0;
      len_sr   <= '0;
      crc_sr   <= '0;
      pl_valid <= 1'b0;
      pl_bit   <= 1'b0;
    end else begin
      pl_valid <= (state == ST_LOAD);
      pl_bit   <= ser_in;
      unique case (state)
        ST_HUNT: begin
          cnt <= '0;
          if (sync_hit) state <= ST_LEN;
        end
        ST_LEN: begin
          len_sr <= len_word;
          if (cnt == LEN_LAST) begin
            cnt   <= '0;
            state <= (len_word == '0) ? ST_CRC : ST_LOAD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_LOAD: begin
          if (cnt == len_sr - 1'b1) begin
            cnt   <= '0;
            state <= ST_CRC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CRC: begin
          crc_sr <= crc_word;
          if (cnt == CRC_LAST) begin
            cnt   <= '0;
            state <= (crc_word == crc_val) ? ST_REL : ST_ERR;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_REL:  if (done_line) state <= ST_PHA;
        ST_PHA:  state <= ST_PHB;
        ST_PHB:  state <= ST_CFG;
        ST_CFG:  state <= ST_CFG;
        ST_ERR:  state <= ST_ERR;
        default: state <= ST_ERR;
      endcase
    end
  end
endmodule

// File: rtl/chain_cfg_node.sv
module chain_cfg_node
  import chain_cfg_pkg::*;
#(
  parameter int unsigned      SYNC_W    = 32,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 32'h3C5A_96E1,
  parameter int unsigned      LEN_W     = 32,
  parameter int unsigned      CRC_W     = 32,
  parameter logic [CRC_W-1:0] CRC_POLY  = 32'h04C1_1DB7
) (
  input  logic cfg_clk,
  input  logic rst_n,
  input  logic ser_in,
  output logic ser_out,
  output logic done_pull,
  input  logic done_line,
  output logic pl_valid,
  output logic pl_bit,
  output logic configured,
  output logic crc_err
);
  node_state_e      state;
  logic             hunting;
  logic             sync_hit;
  logic             crc_init;
  logic             crc_en;
  logic [CRC_W-1:0] crc_val;

  ccs_sync_det #(.W(SYNC_W), .PATTERN(SYNC_WORD)) u_sync (
    .cfg_clk (cfg_clk),
    .rst_n   (rst_n),
    .en      (hunting),
    .bit_in  (ser_in),
    .hit     (sync_hit)
  );

  ccs_crc_ser #(.W(CRC_W), .POLY(CRC_POLY), .SEED('1)) u_crc (
    .cfg_clk (cfg_clk),
    .rst_n   (rst_n),
    .init    (crc_init),
    .en      (crc_en),
    .bit_in  (ser_in),
    .crc     (crc_val)
  );

  ccs_fwd u_fwd (
    .cfg_clk (cfg_clk),
    .rst_n   (rst_n),
    .pass    (hunting),
    .bit_in  (ser_in),
    .ser_out (ser_out)
  );

  ccs_seq #(.LEN_W(LEN_W), .CRC_W(CRC_W)) u_seq (
    .cfg_clk   (cfg_clk),
    .rst_n     (rst_n),
    .ser_in    (ser_in),
    .sync_hit  (sync_hit),
    .crc_val   (crc_val),
    .done_line (done_line),
    .state     (state),
    .hunting   (hunting),
    .crc_init  (crc_init),
    .crc_en    (crc_en),
    .pl_valid  (pl_valid),
    .pl_bit    (pl_bit)
  );

  // open-drain: only an enable to pull low, released from the release phase on
  assign done_pull  = !((state == ST_REL) || (state == ST_PHA) ||
                        (state == ST_PHB) || (state == ST_CFG));
  assign configured = (state == ST_CFG);
  assign crc_err    = (state == ST_ERR);
endmodule

// File: rtl/chain_cfg_node_chk.sv
module chain_cfg_node_chk (
  input logic cfg_clk,
  input logic rst_n,
  input logic ser_out,
  input logic done_pull,
  input logic done_line,
  input logic pl_valid,
  input logic configured,
  input logic crc_err
);
  assert_err_pulls_R9: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    crc_err |-> done_pull);

  assert_err_sticky_R9: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    crc_err |=> crc_err);

  assert_cfg_sticky_R8: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    configured |=> configured);

  assert_cfg_after_done_R8: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    $rose(configured) |-> $past(done_line, 3));

  assert_exclusive_R10: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !(configured && crc_err));

  assert_released_when_cfg_R10: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    configured |-> !done_pull);

  assert_load_still_pulls_R6: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    pl_valid |-> done_pull);

  assert_idle_out_R2: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (configured || pl_valid) |-> ser_out);
endmodule

bind chain_cfg_node chain_cfg_node_chk u_chk (
  .cfg_clk    (cfg_clk),
  .rst_n      (rst_n),
  .ser_out    (ser_out),
  .done_pull  (done_pull),
  .done_line  (done_line),
  .pl_valid   (pl_valid),
  .configured (configured),
  .crc_err    (crc_err)
);

// File: tb/sim_chain_cfg_node.sv
module sim_chain_cfg_node;
  localparam logic [31:0] SYNC = 32'h3C5A_96E1;
  localparam logic [31:0] POLY = 32'h04C1_1DB7;

  logic cfg_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic ser_in  = 1'b0;
  logic done_line = 1'b0;
  logic ser_out, done_pull, pl_valid, pl_bit, configured, crc_err;

  int checks = 0;
  int errors = 0;

  chain_cfg_node u0 (
    .cfg_clk    (cfg_clk),
    .rst_n      (rst_n),
    .ser_in     (ser_in),
    .ser_out    (ser_out),
    .done_pull  (done_pull),
    .done_line  (done_line),
    .pl_valid   (pl_valid),
    .pl_bit     (pl_bit),
    .configured (configured),
    .crc_err    (crc_err)
  );

  always #4 cfg_clk = ~cfg_clk;

  initial begin
    #1_200_000;
    errors++;
    $display("FAIL watchdog: run hung, act=timeout exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [63:0] d, input int n);
    logic [31:0] c = '1;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb;
      fb = c[31] ^ d[i];
      c  = {c[30:0], 1'b0} ^ (fb ? POLY : 32'h0);
    end
    return c;
  endfunction

  // called at negedge+1, returns at the next negedge+1
  task automatic send_bit(input logic b);
    ser_in = b;
    @(posedge cfg_clk);
    @(negedge cfg_clk);
    #1;
  endtask

  task automatic send_word(input logic [63:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; ser_in = 1'b0; done_line = 1'b0;
    @(negedge cfg_clk); @(negedge cfg_clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic t_reset;
    do_reset();
    chk("R2", "ser_out at reset", ser_out, 1);
    chk("R6", "done_pull at reset", done_pull, 1);
    chk("R10", "configured at reset", configured, 0);
    chk("R10", "crc_err at reset", crc_err, 0);
  endtask

  task automatic t_forward;
    logic [15:0] g = 16'hC3A5;
    do_reset();
    for (int i = 15; i >= 0; i--) begin
      send_bit(g[i]);
      chk("R1", "forwarded bit", ser_out, g[i]);
    end
    send_bit(1'b1);
    ser_in = 1'b0;
    @(posedge cfg_clk); #1;
    chk("R1", "no change on rising edge", ser_out, 1);
    @(negedge cfg_clk); #1;
    chk("R1", "change on falling edge", ser_out, 0);
  endtask

  // good frame: garbage, sync, length, payload, correct crc, then start-up
  task automatic t_good(input logic [7:0] g, input logic [63:0] pl, input int n);
    logic [31:0] c = ref_crc(pl, n);
    do_reset();
    for (int i = 7; i >= 0; i--) begin
      send_bit(g[i]);
      chk("R1", "pre-sync forward", ser_out, g[i]);
    end
    send_word({32'h0, SYNC}, 32);
    chk("R1", "last sync bit forwarded", ser_out, SYNC[0]);
    send_word(64'(n), 32);   // R3 length field
    chk("R2", "ser_out idle after sync", ser_out, 1);
    chk("R4", "no valid on length bits", pl_valid, 0);
    for (int i = n - 1; i >= 0; i--) begin
      send_bit(pl[i]);
      chk("R4", "payload valid", pl_valid, 1);
      chk("R4", "payload bit", pl_bit, pl[i]);
      chk("R6", "pull during load", done_pull, 1);
    end
    send_bit(c[31]);
    chk("R4", "no valid on crc bits", pl_valid, 0);
    send_word({32'h0, c}, 31);
    chk("R5", "crc accepted", crc_err, 0);
    chk("R7", "done released", done_pull, 0);
    for (int k = 0; k < 5; k++) send_bit(k[0]);
    chk("R7", "held while line low", configured, 0);
    chk("R7", "still released", done_pull, 0);
    done_line = 1'b1;
    send_bit(1'b0);
    send_bit(1'b0);
    chk("R8", "not yet configured after 2 edges", configured, 0);
    send_bit(1'b0);
    chk("R8", "configured after 3 edges", configured, 1);
    done_line = 1'b0;
    send_word({32'h0, SYNC}, 32);
    chk("R8", "configured holds", configured, 1);
    chk("R10", "released while configured", done_pull, 0);
    chk("R2", "ser_out idle when configured", ser_out, 1);
  endtask

  task automatic t_zero;
    do_reset();
    send_word({32'h0, SYNC}, 32);
    send_word(64'h0, 32);
    send_word({32'h0, 32'hFFFF_FFFF}, 32);
    chk("R5", "zero-length crc accepted", done_pull, 0);
    chk("R5", "zero-length no error", crc_err, 0);
  endtask

  task automatic t_bad;
    logic [63:0] pl = 64'hB6;
    logic [31:0] c = ref_crc(pl, 8) ^ 32'h0000_0100;
    do_reset();
    send_word({32'h0, SYNC}, 32);
    send_word(64'd8, 32);
    send_word(pl, 8);
    send_word({32'h0, c}, 32);
    chk("R9", "error on mismatch", crc_err, 1);
    chk("R9", "pull kept on error", done_pull, 1);
    done_line = 1'b1;
    send_word({32'h0, SYNC}, 32);
    send_word(64'h0, 32);
    send_word({32'h0, 32'hFFFF_FFFF}, 32);
    chk("R9", "error sticky", crc_err, 1);
    chk("R9", "no configure after error", configured, 0);
    chk("R9", "no forward after error", ser_out, 1);
    chk("R9", "pull still on", done_pull, 1);
    do_reset();
    chk("R9", "reset clears error", crc_err, 0);
  endtask

  initial begin
    t_reset();
    t_forward();
    t_good(8'h6B, 64'hA3F1C, 20);
    t_good(8'h91, 64'h1A_5C3E_9D47, 37);
    t_zero();
    t_bad();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule